// File: doc/BRIEF.md
# Event Register with Interrupt Masking

This block collects per-port and global event flags for a multi-port power controller and drives an active-low interrupt line toward a host. Each port's monitoring pass ends with a strobe that carries the port number, its new status code and any event pulses seen during the pass. The block moves that result through a fixed chain of registers: status first, then the sticky event flags, then a per-source interrupt summary, and finally the pin. Because each link is a register, the pin trails the event flags by two cycles and the status by three.

The host reaches the block through a small register port with combinational read data. The event flags appear at two neighbouring addresses. One returns the flags without changing them. The other returns them and clears them all on the same read strobe. A per-bit mask register decides which flags may pull the pin low. Global event pulses go straight into the flag register, without passing through the port stage.

Top module: `evt_irq_ctrl`

## Requirements
- R1: The status field of the selected port (bits [2p+1:2p] of the status view at address 0) takes the strobed status value one cycle after the port-done strobe. The other ports' fields stay unchanged.
- R2: Event pulses carried with a port-done strobe are OR-ed into that port's event flags (bits [2p+1:2p] of the event view) two cycles after the strobe. Flags stay set until cleared.
- R3: Global event pulses set the global flags (event view bits [9:8]) one cycle after they are applied.
- R4: The summary view at address 4 has bit p set when port p has any unmasked flag, and bit 4 set when any unmasked global flag is set. It trails the event flags by one cycle.
- R5: The interrupt pin is low one cycle after the summary is non-zero and high one cycle after it is zero.
- R6: Reading address 1 returns the event flags and leaves them unchanged, even with the read strobe held.
- R7: A read strobe at address 2 returns the event flags in that cycle and clears all of them at the following edge.
- R8: A flag being set in the same cycle as a clearing read survives the clear.
- R9: The mask register at address 3 is writable and reads back. A mask bit of 1 keeps the matching event flag out of the summary and off the pin.
- R10: After reset, all status and event bits are 0, every mask bit is 1 (masked), the summary is 0 and the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pass_done_i | input | 1 | One-cycle strobe marking the end of a port's monitoring pass |
| pass_port_i | input | 2 | Port number for the strobe |
| pass_stat_i | input | 2 | New status code for that port |
| pass_evt_i | input | 2 | Event pulses for that port |
| glob_evt_i | input | 2 | Global event pulses |
| reg_rd_i | input | 1 | Read strobe (causes clearing at address 2) |
| reg_wr_i | input | 1 | Write strobe (effective at address 3 only) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 10 | Combinational read data; unused bits and unmapped addresses read 0 |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Each result has a fixed due cycle. After a port-done strobe, the status is due after one edge, the event flags after two, the summary after three and the pin after four. A global pulse moves each of these one edge earlier, and a mask write reaches the summary after two edges and the pin after three. The bench drives its inputs just after a rising edge and samples read data and the pin a few nanoseconds later. At every stage it checks both the newly due value and that the next stage still holds the old value. Clearing reads are checked in the same cycle for the returned data, and again after the edge for the emptied flags and for any flag set in the same cycle.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;
   typedef enum logic [2:0] {
      A_STAT = 3'd0,
      A_PEEK = 3'd1,
      A_TAKE = 3'd2,
      A_MASK = 3'd3,
      A_SUMM = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/evt_port_stage.sv
module evt_port_stage #(
   parameter int NP   = 4,
   parameter int SW   = 2,
   parameter int PEW  = 2,
   parameter int SELW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [SELW-1:0]   sel_i,
   input  logic [SW-1:0]     stat_i,
   input  logic [PEW-1:0]    evt_i,
   output logic [NP*SW-1:0]  stat_o,
   output logic [NP*PEW-1:0] set_o
);
   for (genvar p = 0; p < NP; p++) begin : g_port
      logic           hit;
      logic [SW-1:0]  stat_q;
      logic [PEW-1:0] set_q;

      assign hit = done_i && (sel_i == SELW'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat_q <= '0;
            set_q  <= '0;
         end else begin
            if (hit) stat_q <= stat_i;
            set_q <= hit ? evt_i : '0;
         end
      end

      assign stat_o[p*SW +: SW]   = stat_q;
      assign set_o[p*PEW +: PEW]  = set_q;
   end
endmodule

// File: rtl/evt_bank.sv
module evt_bank #(
   parameter int EW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [EW-1:0] set_i,
   input  logic          clr_i,
   output logic [EW-1:0] evt_o
);
   logic [EW-1:0] evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= (clr_i ? '0 : evt_q) | set_i;
   end

   assign evt_o = evt_q;

   // R2 R3
   evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((evt_q & $past(set_i)) == $past(set_i)));

   // R7
   evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i == '0) |=> (evt_q == '0));

   // R8
   evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> ((evt_q & ~$past(set_i)) == '0));

   // R6
   evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && set_i == '0) |=> $stable(evt_q));
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
   parameter int NP  = 4,
   parameter int PEW = 2,
   parameter int GW  = 2,
   localparam int EW = NP*PEW + GW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [EW-1:0] evt_i,
   input  logic [EW-1:0] mask_i,
   output logic [NP:0]   sum_o,
   output logic          irq_n_o
);
   logic [EW-1:0] live;
   logic [NP:0]   hit;
   logic [NP:0]   sum_q;
   logic          irq_n_q;

   assign live = evt_i & ~mask_i;

   for (genvar p = 0; p < NP; p++) begin : g_src
      assign hit[p] = |live[p*PEW +: PEW];
   end
   assign hit[NP] = |live[EW-1 -: GW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q   <= '0;
         irq_n_q <= 1'b1;
      end else begin
         sum_q   <= hit;
         irq_n_q <= ~|sum_q;
      end
   end

   assign sum_o   = sum_q;
   assign irq_n_o = irq_n_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evtirq_pkg::*;
#(
   parameter int NP  = 4,
   parameter int SW  = 2,
   parameter int PEW = 2,
   parameter int GW  = 2,
   localparam int SELW = (NP > 1) ? $clog2(NP) : 1,
   localparam int EW   = NP*PEW + GW,
   localparam int STW  = NP*SW,
   localparam int DW0  = (EW > STW) ? EW : STW,
   localparam int DW   = (DW0 > NP+1) ? DW0 : NP+1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pass_done_i,
   input  logic [SELW-1:0] pass_port_i,
   input  logic [SW-1:0]   pass_stat_i,
   input  logic [PEW-1:0]  pass_evt_i,
   input  logic [GW-1:0]   glob_evt_i,
   input  logic            reg_rd_i,
   input  logic            reg_wr_i,
   input  logic [2:0]      reg_addr_i,
   input  logic [DW-1:0]   reg_wdata_i,
   output logic [DW-1:0]   reg_rdata_o,
   output logic            irq_n_o
);
   if (NP < 1)  begin : g_np_bad  $error("NP must be at least 1");  end
   if (SW < 1)  begin : g_sw_bad  $error("SW must be at least 1");  end
   if (PEW < 1) begin : g_pew_bad $error("PEW must be at least 1"); end
   if (GW < 1)  begin : g_gw_bad  $error("GW must be at least 1");  end

   logic [STW-1:0]    stat_w;
   logic [NP*PEW-1:0] pset_w;
   logic [EW-1:0]     evt_w;
   logic [EW-1:0]     mask_q;
   logic [NP:0]       sum_w;
   logic              take_w;

   assign take_w = reg_rd_i && (reg_addr_i == A_TAKE);

   evt_port_stage #(.NP(NP), .SW(SW), .PEW(PEW), .SELW(SELW)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .done_i (pass_done_i),
      .sel_i  (pass_port_i),
      .stat_i (pass_stat_i),
      .evt_i  (pass_evt_i),
      .stat_o (stat_w),
      .set_o  (pset_w)
   );

   evt_bank #(.EW(EW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i ({glob_evt_i, pset_w}),
      .clr_i (take_w),
      .evt_o (evt_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mask_q <= '1;
      else if (reg_wr_i && reg_addr_i == A_MASK) mask_q <= reg_wdata_i[EW-1:0];
   end

   evt_irq_out #(.NP(NP), .PEW(PEW), .GW(GW)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_w),
      .mask_i  (mask_q),
      .sum_o   (sum_w),
      .irq_n_o (irq_n_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_STAT:         reg_rdata_o[STW-1:0] = stat_w;
         A_PEEK, A_TAKE: reg_rdata_o[EW-1:0]  = evt_w;
         A_MASK:         reg_rdata_o[EW-1:0]  = mask_q;
         A_SUMM:         reg_rdata_o[NP:0]    = sum_w;
         default:        reg_rdata_o          = '0;
      endcase
   end

   logic [EW-1:0] live_w;
   assign live_w = evt_w & ~mask_q;

   // R5
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((live_w != '0) && $past(live_w != '0)) |=> !irq_n_o);

   // R5
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((live_w == '0) && $past(live_w == '0)) |=> irq_n_o);
endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
   import evtirq_pkg::*;

   localparam int NP = 4, SW = 2, PEW = 2, GW = 2;
   localparam int EW = 10, DW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic           pass_done = 1'b0;
   logic [1:0]     pass_port = '0;
   logic [SW-1:0]  pass_stat = '0;
   logic [PEW-1:0] pass_evt = '0;
   logic [GW-1:0]  glob_evt = '0;
   logic           reg_rd = 1'b0, reg_wr = 1'b0;
   logic [2:0]     reg_addr = '0;
   logic [DW-1:0]  reg_wdata = '0;
   logic [DW-1:0]  reg_rdata;
   logic           irq_n;

   evt_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .pass_done_i(pass_done), .pass_port_i(pass_port), .pass_stat_i(pass_stat),
      .pass_evt_i(pass_evt), .glob_evt_i(glob_evt),
      .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_n_o(irq_n)
   );

   int checks = 0, errors = 0;
   bit fin = 1'b0;
   logic [EW-1:0]      exp_evt = '0;
   logic [EW-1:0]      exp_mask = '1;
   logic [NP*SW-1:0]   exp_stat = '0;

   function automatic logic [NP:0] sumf(input logic [EW-1:0] e, input logic [EW-1:0] m);
      logic [EW-1:0] h;
      logic [NP:0]   s;
      h = e & ~m;
      for (int p = 0; p < NP; p++) s[p] = |h[p*PEW +: PEW];
      s[NP] = |h[EW-1 -: GW];
      return s;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk); #1;
   endtask

   task automatic peek(input logic [2:0] a, output logic [DW-1:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic run_pass(input int p, input int code, input int st);
      logic [DW-1:0] d;
      logic [EW-1:0] old;
      logic [NP:0]   s_old;
      old = exp_evt; s_old = sumf(old, exp_mask);
      pass_port = 2'(p); pass_stat = SW'(st); pass_evt = PEW'(code); pass_done = 1'b1;
      step;
      pass_done = 1'b0; pass_evt = '0;
      exp_stat[p*SW +: SW] = SW'(st);
      peek(A_STAT, d); chk("R1", "status one cycle after strobe", 32'(d), 32'(exp_stat));
      peek(A_PEEK, d); chk("R2", "events not yet set", 32'(d), 32'(old));
      step;
      exp_evt = old | (EW'(code) << (p*PEW));
      peek(A_PEEK, d); chk("R2", "events set two cycles after strobe", 32'(d), 32'(exp_evt));
      peek(A_SUMM, d); chk("R4", "summary still old", 32'(d), 32'(s_old));
      step;
      peek(A_SUMM, d); chk("R4", "summary updated", 32'(d), 32'(sumf(exp_evt, exp_mask)));
      chk("R5", "pin still old", 32'(irq_n), 32'(~|s_old));
      step;
      chk("R5", "pin updated", 32'(irq_n), 32'(~|sumf(exp_evt, exp_mask)));
   endtask

   task automatic glob_pulse(input int g);
      logic [DW-1:0] d;
      logic [EW-1:0] old;
      old = exp_evt;
      glob_evt = GW'(g);
      step;
      glob_evt = '0;
      exp_evt = old | (EW'(g) << (NP*PEW));
      peek(A_PEEK, d); chk("R3", "global flag after one cycle", 32'(d), 32'(exp_evt));
      peek(A_SUMM, d); chk("R4", "summary still old", 32'(d), 32'(sumf(old, exp_mask)));
      step;
      peek(A_SUMM, d); chk("R4", "summary after global", 32'(d), 32'(sumf(exp_evt, exp_mask)));
      chk("R5", "pin still old", 32'(irq_n), 32'(~|sumf(old, exp_mask)));
      step;
      chk("R5", "pin after global", 32'(irq_n), 32'(~|sumf(exp_evt, exp_mask)));
   endtask

   task automatic take;
      logic [DW-1:0] d;
      reg_addr = A_TAKE; reg_rd = 1'b1; #1;
      chk("R7", "clearing read returns flags", 32'(reg_rdata), 32'(exp_evt));
      step;
      reg_rd = 1'b0; exp_evt = '0;
      peek(A_PEEK, d); chk("R7", "flags cleared", 32'(d), 32'(0));
      step; step;
      chk("R5", "pin released after clear", 32'(irq_n), 32'(1));
   endtask

   task automatic wmask(input logic [EW-1:0] m);
      reg_addr = A_MASK; reg_wdata = m; reg_wr = 1'b1;
      step;
      reg_wr = 1'b0; exp_mask = m;
   endtask

   initial begin
      logic [DW-1:0] d;
      repeat (3) step;
      rst_n = 1'b1;
      step;
      // R10 reset state
      peek(A_STAT, d); chk("R10", "status after reset", 32'(d), 32'(0));
      peek(A_PEEK, d); chk("R10", "events after reset", 32'(d), 32'(0));
      peek(A_MASK, d); chk("R10", "mask after reset", 32'(d), 32'h3FF);
      peek(A_SUMM, d); chk("R10", "summary after reset", 32'(d), 32'(0));
      chk("R10", "pin after reset", 32'(irq_n), 32'(1));

      // R9 all masked: events land but pin stays high
      run_pass(0, 1, 1);
      chk("R9", "masked event keeps pin high", 32'(irq_n), 32'(1));
      take;
      wmask('0);
      peek(A_MASK, d); chk("R9", "mask readback", 32'(d), 32'(0));

      // R1 R2 sweep over ports and codes, two passes accumulate
      for (int p = 0; p < NP; p++) begin
         for (int c = 1; c < 4; c++) begin
            run_pass(p, c, (p + c) % 4);
            run_pass((p + 1) % NP, 4 - c, (p + 2 * c) % 4);
            take;
         end
      end

      // R9 per-bit mask sweep
      for (int i = 0; i < EW; i++) begin
         wmask(10'h3FF);
         if (i < NP*PEW) run_pass(i / PEW, 1 << (i % PEW), i % 4);
         else            glob_pulse(1 << (i - NP*PEW));
         chk("R9", "masked bit keeps pin high", 32'(irq_n), 32'(1));
         wmask(EW'(~(EW'(1) << i)));
         peek(A_SUMM, d); chk("R9", "summary waits after unmask", 32'(d), 32'(0));
         step;
         peek(A_SUMM, d); chk("R9", "summary after unmask", 32'(d), 32'(sumf(exp_evt, exp_mask)));
         chk("R9", "pin still high", 32'(irq_n), 32'(1));
         step;
         chk("R9", "pin low after unmask", 32'(irq_n), 32'(0));
         take;
      end
      wmask('0);

      // R3 global pulses
      glob_pulse(1);
      glob_pulse(2);
      // R6 plain reads with strobe held leave flags
      reg_addr = A_PEEK; reg_rd = 1'b1;
      step; step; step;
      reg_rd = 1'b0;
      peek(A_PEEK, d); chk("R6", "plain read keeps flags", 32'(d), 32'(exp_evt));
      chk("R6", "pin still asserted", 32'(irq_n), 32'(0));
      take;

      // R8 global set during clearing read
      glob_pulse(1);
      reg_addr = A_TAKE; reg_rd = 1'b1; glob_evt = 2'b10; #1;
      chk("R7", "clearing read data", 32'(reg_rdata), 32'h100);
      step;
      reg_rd = 1'b0; glob_evt = '0;
      peek(A_PEEK, d); chk("R8", "global set survives clear", 32'(d), 32'h200);
      // R8 port set landing during clearing read
      pass_port = 2'd1; pass_stat = 2'd2; pass_evt = 2'b01; pass_done = 1'b1;
      step;
      pass_done = 1'b0; pass_evt = '0;
      exp_stat[1*SW +: SW] = 2'd2;
      reg_addr = A_TAKE; reg_rd = 1'b1; #1;
      step;
      reg_rd = 1'b0;
      exp_evt = 10'h004;
      peek(A_PEEK, d); chk("R8", "port set survives clear", 32'(d), 32'h004);
      peek(A_STAT, d); chk("R1", "status of port 1", 32'(d), 32'(exp_stat));
      step;
      take;

      fin = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule